// File: doc/BRIEF.md
# Program Counter and Return-Stack Sequencer

This block owns the program counter of a small virtual CPU with 8-bit data registers and a 16-entry return-address stack. It fetches each 16-bit instruction from a byte-wide synchronous memory in two reads, big-endian: the byte at the counter first, then the byte that follows it. The counter then advances by two. The assembled opcode leaves the block on a valid/ready stream. Once a downstream decoder has accepted the opcode, the block waits for one control-flow command that tells it how to move the counter: keep going, jump, call, return, skip conditionally, or jump to a target offset by a register value.

The opcode stream is under back-pressure. While `op_valid` is high and `op_ready` is low, the opcode and the counter hold, and no new fetch starts. The command port is also valid/ready, but `cmd_ready` is only raised after the opcode has been taken. A command presented earlier stays pending and is not consumed. Memory is 4096 bytes, so every address presented is the counter modulo 4096. The counter register itself keeps 16 bits. A call made with the stack full, or a return made with it empty, leaves the counter and the stack untouched and sets a fault flag that stays set until reset.

Top module: `pc_sequencer`

## Requirements
- R1: After reset the counter reads 0x200, the stack is empty, the fault flag is 0, `op_valid` is 0 and the first read goes to address 0x200.
- R2: Each instruction is built with the byte at address PC in bits 15:8 and the byte at (PC+1) mod 4096 in bits 7:0. When the opcode is offered, the counter has advanced by 2. Memory has one cycle of read latency.
- R3: While `op_valid` is high and `op_ready` is low, `op_valid` stays high and `op_data` stays unchanged. The opcode is consumed on the first clock with both high.
- R4: `cmd_ready` is high only after the opcode handshake and stays high until a command is taken. It is never high together with `op_valid` or a memory read. A command held on the port earlier has no effect until then.
- R5: Command kind 0 (advance), and the unused kinds 6 and 7, leave the advanced counter as it is.
- R6: Command kind 1 (jump) loads the counter with the 12-bit target.
- R7: Command kind 2 (call) raises the stack depth by one, stores the advanced counter in the new top slot, and loads the counter with the target.
- R8: Command kind 3 (return) loads the counter from the top slot and lowers the depth by one. Nested calls return in last-in, first-out order.
- R9: Command kind 4 (skip) adds a further 2 to the counter when `cmd_take` is 1, and changes nothing when it is 0.
- R10: Command kind 5 (offset jump) loads the counter with the target plus the 8-bit `cmd_base`, without truncation to 12 bits. Fetch addresses then wrap modulo 4096.
- R11: A call made while the stack already holds 15 return addresses sets the fault flag and leaves the counter and the stack unchanged.
- R12: A return made with the stack empty sets the fault flag and leaves the counter unchanged.
- R13: Once set, the fault flag stays set until reset, and the block keeps fetching and executing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Byte read address |
| mem_rd | output | 1 | Read strobe; data returns one cycle later |
| mem_rdata | input | 8 | Read data |
| op_data | output | 16 | Fetched opcode |
| op_valid | output | 1 | Opcode offered |
| op_ready | input | 1 | Downstream takes the opcode |
| cmd_valid | input | 1 | Control-flow command offered |
| cmd_ready | output | 1 | Block takes the command |
| cmd_kind | input | 3 | Command kind (encodings in R5 to R10) |
| cmd_target | input | 12 | Jump, call or offset target |
| cmd_base | input | 8 | Offset for kind 5 |
| cmd_take | input | 1 | Skip condition for kind 4 |
| pc_o | output | 16 | Current program counter |
| fault_o | output | 1 | Sticky stack fault flag |

## Verification
Several properties are checked on every cycle: the held opcode under back-pressure, the mutual exclusion of offer, command and read phases, the frozen counter while an opcode waits, stack depth changing only on an accepted command, the stickiness of the fault flag, and the counter and depth staying put on the cycle a fault appears. Only the bench scenarios can show the actual values: opcode byte order at the wrap from 0xFFF to 0x000, jump, skip and offset targets, the LIFO return sequence across fifteen nested calls, and the exact overflow and underflow points.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
  typedef enum logic [2:0] {
    ACT_NEXT = 3'd0,
    ACT_JUMP = 3'd1,
    ACT_CALL = 3'd2,
    ACT_RET  = 3'd3,
    ACT_SKIP = 3'd4,
    ACT_VJMP = 3'd5
  } act_e;

  typedef enum logic [2:0] {
    F_HI    = 3'd0,
    F_LO    = 3'd1,
    F_CAP   = 3'd2,
    F_OFFER = 3'd3,
    F_CMD   = 3'd4
  } fstate_e;
endpackage

// File: rtl/seqr_fetch.sv
module seqr_fetch
  import seqr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PC_W   = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PC_W-1:0]     pc,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic [2*BYTE_W-1:0] op_data,
  output logic                op_valid,
  input  logic                op_ready,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  output logic                advance,
  output logic                apply
);
  fstate_e st, st_n;
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic [ADDR_W-1:0] base_addr;

  assign base_addr = pc[ADDR_W-1:0];

  always_comb begin
    st_n = st;
    case (st)
      F_HI:    st_n = F_LO;
      F_LO:    st_n = F_CAP;
      F_CAP:   st_n = F_OFFER;
      F_OFFER: if (op_ready) st_n = F_CMD;
      F_CMD:   if (cmd_valid) st_n = F_HI;
      default: st_n = F_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= F_HI;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      st <= st_n;
      if (st == F_LO)  hi_q <= mem_rdata;
      if (st == F_CAP) lo_q <= mem_rdata;
    end
  end

  assign mem_rd    = (st == F_HI) || (st == F_LO);
  assign mem_addr  = (st == F_LO) ? base_addr + ADDR_W'(1) : base_addr;
  assign op_data   = {hi_q, lo_q};
  assign op_valid  = (st == F_OFFER);
  assign cmd_ready = (st == F_CMD);
  assign advance   = (st == F_CAP);
  assign apply     = cmd_ready && cmd_valid;
endmodule

// File: rtl/seqr_stack.sv
module seqr_stack #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    top,
  output logic [SP_W-1:0] level,
  output logic            full,
  output logic            empty
);
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] wr_idx;
  logic [W-1:0]    slot_v [DEPTH];

  assign wr_idx = sp_q + SP_W'(1);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (push && wr_idx == SP_W'(g)) q <= din;
    end
    assign slot_v[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= '0;
    else if (push) sp_q <= wr_idx;
    else if (pop)  sp_q <= sp_q - SP_W'(1);
  end

  assign top   = slot_v[sp_q];
  assign level = sp_q;
  assign full  = (sp_q == SP_W'(DEPTH - 1));
  assign empty = (sp_q == '0);
endmodule

// File: rtl/seqr_target.sv
module seqr_target
  import seqr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PC_W   = 16,
  parameter int BYTE_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] target,
  input  logic [BYTE_W-1:0] base,
  input  logic              take,
  input  logic [PC_W-1:0]   stk_top,
  input  logic              stk_full,
  input  logic              stk_empty,
  output logic [PC_W-1:0]   pc_next,
  output logic              push,
  output logic              pop,
  output logic              fault_hit
);
  localparam logic [PC_W-1:0] STEP = PC_W'(2);
  logic [PC_W-1:0] tgt_w, base_w;

  assign tgt_w  = {{(PC_W-ADDR_W){1'b0}}, target};
  assign base_w = {{(PC_W-BYTE_W){1'b0}}, base};

  always_comb begin
    pc_next   = pc;
    push      = 1'b0;
    pop       = 1'b0;
    fault_hit = 1'b0;
    case (act_e'(kind))
      ACT_JUMP: pc_next = tgt_w;
      ACT_CALL: begin
        if (stk_full) fault_hit = 1'b1;
        else begin
          push    = 1'b1;
          pc_next = tgt_w;
        end
      end
      ACT_RET: begin
        if (stk_empty) fault_hit = 1'b1;
        else begin
          pop     = 1'b1;
          pc_next = stk_top;
        end
      end
      ACT_SKIP: if (take) pc_next = pc + STEP;
      ACT_VJMP: pc_next = tgt_w + base_w;
      default:  pc_next = pc;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int ADDR_W              = 12,
  parameter int PC_W                = 16,
  parameter int BYTE_W              = 8,
  parameter int DEPTH               = 16,
  parameter logic [PC_W-1:0] RST_PC = 16'h0200
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  input  logic [BYTE_W-1:0]   mem_rdata,
  output logic [2*BYTE_W-1:0] op_data,
  output logic                op_valid,
  input  logic                op_ready,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [2:0]          cmd_kind,
  input  logic [ADDR_W-1:0]   cmd_target,
  input  logic [BYTE_W-1:0]   cmd_base,
  input  logic                cmd_take,
  output logic [PC_W-1:0]     pc_o,
  output logic                fault_o
);
  localparam int SP_W = $clog2(DEPTH);

  logic [PC_W-1:0] pc_q, pc_next, stk_top;
  logic            advance, apply;
  logic            want_push, want_pop, fault_hit;
  logic            stk_full, stk_empty, fault_q;
  logic [SP_W-1:0] stk_level;

  seqr_fetch #(.ADDR_W(ADDR_W), .PC_W(PC_W), .BYTE_W(BYTE_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .pc(pc_q), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .op_data(op_data),
    .op_valid(op_valid), .op_ready(op_ready), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .advance(advance), .apply(apply)
  );

  seqr_target #(.ADDR_W(ADDR_W), .PC_W(PC_W), .BYTE_W(BYTE_W)) u_target (
    .pc(pc_q), .kind(cmd_kind), .target(cmd_target), .base(cmd_base),
    .take(cmd_take), .stk_top(stk_top), .stk_full(stk_full),
    .stk_empty(stk_empty), .pc_next(pc_next), .push(want_push),
    .pop(want_pop), .fault_hit(fault_hit)
  );

  seqr_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(apply && want_push),
    .pop(apply && want_pop), .din(pc_q), .top(stk_top),
    .level(stk_level), .full(stk_full), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= RST_PC;
      fault_q <= 1'b0;
    end else begin
      if (advance)    pc_q <= pc_q + PC_W'(2);
      else if (apply) pc_q <= pc_next;
      if (apply && fault_hit) fault_q <= 1'b1;
    end
  end

  assign pc_o    = pc_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/seqr_checker.sv
module seqr_checker #(
  parameter int PC_W  = 16,
  parameter int OP_W  = 16,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [OP_W-1:0]  op_data,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             mem_rd,
  input logic [PC_W-1:0]  pc_o,
  input logic             fault_o,
  input logic [LVL_W-1:0] level
);
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_data)); // R3
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_valid, cmd_ready, mem_rd})); // R4
  AST_PC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> $stable(pc_o)); // R4
  AST_DEPTH_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> $past(cmd_valid && cmd_ready)); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> fault_o); // R13
  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $stable(pc_o) && $stable(level)); // R11
  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(cmd_valid && cmd_ready)); // R12
endmodule

bind pc_sequencer seqr_checker #(.PC_W(PC_W), .OP_W(2*BYTE_W), .LVL_W(SP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_data(op_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .mem_rd(mem_rd), .pc_o(pc_o), .fault_o(fault_o), .level(stk_level)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] op_data;
  logic        op_valid;
  logic        op_ready = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_kind = '0;
  logic [11:0] cmd_target = '0;
  logic [7:0]  cmd_base = '0;
  logic        cmd_take = 1'b0;
  logic [15:0] pc_o;
  logic        fault_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  mem [4096];
  logic [15:0] exp_op [$];
  logic [15:0] exp_pc [$];
  logic [15:0] m_pc;
  logic [15:0] m_stk [16];
  int          m_sp;
  bit          m_fault;

  always #4 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .op_data(op_data), .op_valid(op_valid),
    .op_ready(op_ready), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_target(cmd_target), .cmd_base(cmd_base),
    .cmd_take(cmd_take), .pc_o(pc_o), .fault_o(fault_o)
  );

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: pops expected opcode and counter at each handshake
  always @(negedge clk) begin
    if (rst_n && op_valid && op_ready) begin
      if (exp_op.size() == 0) chk(1'b0, "R2 unexpected opcode", 32'(op_data), 32'hx);
      else begin
        logic [15:0] eo, ep;
        eo = exp_op.pop_front();
        ep = exp_pc.pop_front();
        chk(op_data == eo, "R2 opcode bytes", 32'(op_data), 32'(eo));
        chk(pc_o == ep, "R2 advanced counter", 32'(pc_o), 32'(ep));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_ready = 1'b0; cmd_valid = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    m_pc = 16'h0200; m_sp = 0; m_fault = 1'b0;
  endtask

  task automatic model(input int kind, input logic [11:0] tgt, input logic [7:0] base, input bit take);
    case (kind)
      1: m_pc = {4'h0, tgt};
      2: if (m_sp == 15) m_fault = 1'b1;
         else begin m_sp++; m_stk[m_sp] = m_pc; m_pc = {4'h0, tgt}; end
      3: if (m_sp == 0) m_fault = 1'b1;
         else begin m_pc = m_stk[m_sp]; m_sp--; end
      4: if (take) m_pc = m_pc + 16'd2;
      5: m_pc = {4'h0, tgt} + {8'h00, base};
      default: ;
    endcase
  endtask

  // driver: one fetch plus one command, with stall cycles of back-pressure
  task automatic step(input int kind, input logic [11:0] tgt, input logic [7:0] base,
                      input bit take, input int stall, input bit early, input string req);
    logic [11:0] a0;
    a0 = m_pc[11:0];
    exp_op.push_back({mem[a0], mem[a0 + 12'd1]});
    exp_pc.push_back(m_pc + 16'd2);
    cmd_kind = 3'(kind); cmd_target = tgt; cmd_base = base; cmd_take = take;
    if (early) cmd_valid = 1'b1;
    while (!op_valid) tick();
    chk(cmd_ready == 1'b0, "R4 no cmd_ready during offer", 32'(cmd_ready), 0);
    repeat (stall) begin
      tick();
      chk(op_valid == 1'b1, "R3 offer held under stall", 32'(op_valid), 1);
    end
    op_ready = 1'b1;
    tick();
    op_ready = 1'b0;
    m_pc = m_pc + 16'd2;
    chk(cmd_ready == 1'b1, "R4 cmd_ready after handshake", 32'(cmd_ready), 1);
    cmd_valid = 1'b1;
    tick();
    cmd_valid = 1'b0;
    model(kind, tgt, base, take);
    @(negedge clk);
    chk(pc_o == m_pc, req, 32'(pc_o), 32'(m_pc));
    chk(fault_o == m_fault, {req, " fault"}, 32'(fault_o), 32'(m_fault));
    tick();
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 37) ^ (a >> 4) ^ 8'h5A);
    do_reset();
    @(negedge clk);
    chk(pc_o == 16'h0200, "R1 reset counter", 32'(pc_o), 32'h200);
    chk(fault_o == 1'b0, "R1 reset fault", 32'(fault_o), 0);
    chk(op_valid == 1'b0, "R1 reset op_valid", 32'(op_valid), 0);
    chk(mem_addr == 12'h200 && mem_rd, "R1 first read address", 32'(mem_addr), 32'h200);
    tick();

    step(0, 12'h000, 8'h00, 0, 0, 0, "R5 advance");
    step(6, 12'h7AB, 8'h11, 1, 2, 0, "R5 unused kind 6");
    step(1, 12'h345, 8'h00, 0, 3, 0, "R6 jump");
    step(4, 12'h000, 8'h00, 1, 0, 0, "R9 skip taken");
    step(4, 12'h000, 8'h00, 0, 1, 0, "R9 skip not taken");
    step(1, 12'h9C0, 8'h00, 0, 0, 1, "R4 early command");
    step(5, 12'hFF8, 8'h20, 0, 0, 0, "R10 offset jump past 0xFFF");
    step(0, 12'h000, 8'h00, 0, 0, 0, "R10 fetch at wrapped address");
    step(1, 12'hFFF, 8'h00, 0, 0, 0, "R6 jump to last byte");
    step(7, 12'h000, 8'h00, 0, 0, 0, "R2 fetch wraps to 0x000");
    step(2, 12'h400, 8'h00, 0, 0, 0, "R7 call 1");
    step(2, 12'h500, 8'h00, 0, 1, 0, "R7 call 2");
    step(3, 12'h000, 8'h00, 0, 0, 0, "R8 return 2");
    step(3, 12'h000, 8'h00, 0, 0, 0, "R8 return 1");
    for (int i = 0; i < 15; i++) step(2, 12'(12'h100 + i * 16), 8'h00, 0, 0, 0, "R7 deep call");
    step(2, 12'hABC, 8'h00, 0, 0, 0, "R11 overflow call");
    step(0, 12'h000, 8'h00, 0, 0, 0, "R13 fault stays after advance");
    for (int i = 0; i < 15; i++) step(3, 12'h000, 8'h00, 0, 0, 0, "R8 LIFO unwind");
    step(1, 12'h222, 8'h00, 0, 0, 0, "R13 still running after fault");

    do_reset();
    @(negedge clk);
    chk(fault_o == 1'b0, "R13 reset clears fault", 32'(fault_o), 0);
    tick();
    step(3, 12'h000, 8'h00, 0, 0, 0, "R12 underflow return");
    step(4, 12'h000, 8'h00, 1, 0, 0, "R13 fault held after underflow");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired, R2 progress halted actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule